// File: doc/BRIEF.md
# DDR serial output framer

This block takes one parallel sample word per converter channel and sends each word out on its own serial lane, one bit per fast-clock cycle, with the most significant bit first. The fast clock runs at twelve times the sample rate, so each lane carries one complete 12-bit word per sample period. Alongside the lanes the block drives a data clock at half the bit rate, which is six times the sample rate. Lane data changes on every edge of that clock, rising and falling, so a receiver captures it at double data rate. It also drives a frame clock at the sample rate that marks where each word starts.

The fast clock is assumed to be phase-locked to the sample clock and is modelled as a plain input. The parallel word bus is sampled once per frame, in the last bit period of the word currently on the lanes. The new word is therefore loaded in the same edge that shifts out the previous word's last bit, and the next frame starts with no gap. A receiver recovers the words by waiting for the rising edge of the frame clock and then taking one bit per half period of the data clock.

Top module: `ddr_ser_framer`

## Requirements
- R1: Each lane sends its own 12-bit word (lane k takes `word_i[k*12 +: 12]`), one bit per `clk_i` cycle, with bit 11 first and bit 0 last.
- R2: `frame_o` is high for the first 6 bit periods of every frame and low for the last 6.
- R3: `dclk_o` inverts on every `clk_i` cycle, giving 6 periods per frame, so each lane bit lasts exactly half a `dclk_o` period.
- R4: `frame_o` rises in the same cycle in which `dclk_o` falls. `dclk_o` is low while bit 11 is on the lanes and high while bit 0 is on the lanes.
- R5: `word_i` is sampled only at the end of the final bit period of a frame, and the sampled value goes out in the following frame. Values held on `word_i` at any other time have no effect on the lanes.
- R6: During reset and for the whole first frame after reset, all lanes are 0. In reset `frame_o` is 1 and `dclk_o` is 0, and the first frame starts in the first cycle after reset is released.
- R7: Consecutive words follow each other with no idle bit: bit 0 of one word is followed directly by bit 11 of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, twelve times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 96 | Eight 12-bit words, lane k at bits [k*12 +: 12] |
| lane_o | output | 8 | Serial data, one bit per lane |
| dclk_o | output | 1 | Data clock, six times the sample rate |
| frame_o | output | 1 | Frame clock at the sample rate, high for the first half of each word |

## Verification
The bench recovers every word from the lanes by using the frame clock, and it changes `word_i` twice in the middle of each frame before it settles the value that counts. A design that samples too early or too late, or that samples more than once per frame, would send one of these decoy values. Directed words such as all ones, all zeros, alternating bit patterns and the single-MSB value 0x800 expose bit-order reversal and off-by-one shifts, which a design that sends LSB first or drops a bit would get wrong. The first frame after reset must come out as zeros. A design that loads during reset would send whatever was on the bus instead. The phase of the data clock and the frame clock is checked at every bit position, so a frame that is a cycle long or short, or a data clock with the wrong polarity, is caught at once.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  localparam int unsigned DEF_LANES = 8;
  localparam int unsigned DEF_BITS  = 12;

  function automatic int unsigned cnt_width(input int unsigned bits);
    return (bits > 1) ? $clog2(bits) : 1;
  endfunction
endpackage

// File: rtl/ser_bit_ctr.sv
module ser_bit_ctr #(
  parameter int unsigned BITS = ddr_ser_pkg::DEF_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic frame_o
);
  localparam int unsigned CW   = ddr_ser_pkg::cnt_width(BITS);
  localparam int unsigned HALF = BITS / 2;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          frame_q;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      frame_q <= (cnt_d < CW'(HALF));
    end
  end

  assign load_o  = (cnt_q == LAST);
  assign frame_o = frame_q;
endmodule

// File: rtl/ser_clk_div.sv
module ser_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic dclk_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  assign dclk_o = tgl_q;
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int unsigned BITS = ddr_ser_pkg::DEF_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] word_i,
  output logic            bit_o
);
  logic [BITS-1:0] sh_q;

  // load replaces the outgoing LSB, so frames abut with no idle bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= word_i;
    else             sh_q <= {sh_q[BITS-2:0], 1'b0};
  end

  assign bit_o = sh_q[BITS-1];
endmodule

// File: rtl/ddr_ser_framer.sv
module ddr_ser_framer #(
  parameter int unsigned LANES = ddr_ser_pkg::DEF_LANES,
  parameter int unsigned BITS  = ddr_ser_pkg::DEF_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LANES*BITS-1:0] word_i,
  output logic [LANES-1:0]      lane_o,
  output logic                  dclk_o,
  output logic                  frame_o
);
  logic load_w;

  ser_bit_ctr #(.BITS(BITS)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_o (load_w),
    .frame_o(frame_o)
  );

  ser_clk_div i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dclk_o(dclk_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ser_lane #(.BITS(BITS)) i_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load_w),
      .word_i(word_i[k*BITS +: BITS]),
      .bit_o (lane_o[k])
    );
  end
endmodule

// File: rtl/ddr_ser_framer_chk.sv
module ddr_ser_framer_chk #(
  parameter int unsigned LANES = ddr_ser_pkg::DEF_LANES,
  parameter int unsigned BITS  = ddr_ser_pkg::DEF_BITS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [LANES*BITS-1:0] word_i,
  input logic [LANES-1:0]      lane_o,
  input logic                  dclk_o,
  input logic                  frame_o
);
  localparam int unsigned HALF = BITS / 2;
  localparam int unsigned LW   = ddr_ser_pkg::cnt_width(BITS) + 1;

  logic          seen_q, first_q, frame_prev_q;
  logic [LW-1:0] lvl_len_q;
  logic [LANES-1:0] msb_w;
  logic          rose_w;

  always_comb begin
    for (int k = 0; k < LANES; k++) msb_w[k] = word_i[k*BITS + BITS - 1];
  end

  assign rose_w = frame_o && !frame_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q       <= 1'b0;
      first_q      <= 1'b1;
      frame_prev_q <= 1'b1;
      lvl_len_q    <= '0;
    end else begin
      seen_q       <= 1'b1;
      frame_prev_q <= frame_o;
      if (rose_w) first_q <= 1'b0;
      if (frame_o != frame_prev_q) lvl_len_q <= LW'(1);
      else if (lvl_len_q < LW'(BITS)) lvl_len_q <= lvl_len_q + 1'b1;
    end
  end

  p_frame_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o != frame_prev_q) |-> (lvl_len_q == LW'(HALF)));

  p_dclk_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (dclk_o != $past(dclk_o)));

  p_frame_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rose_w) |-> !dclk_o);

  p_load_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rose_w) |-> (lane_o == $past(msb_w)));

  p_first_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q && !rose_w) |-> (lane_o == '0));
endmodule

bind ddr_ser_framer ddr_ser_framer_chk #(.LANES(LANES), .BITS(BITS)) i_chk (.*);

// File: tb/test_ddr_ser_framer.sv
module test_ddr_ser_framer;
  localparam int unsigned LANES = 8;
  localparam int unsigned BITS  = 12;
  localparam int unsigned HALF  = BITS / 2;
  localparam int unsigned NFRM  = 48;
  localparam time CLK_PERIOD = 10ns;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [LANES*BITS-1:0] word = '0;
  logic [LANES-1:0]      lane;
  logic                  dclk, frame;

  int nchk = 0;
  int nfail = 0;

  ddr_ser_framer #(.LANES(LANES), .BITS(BITS)) i_ddr_ser_framer (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .word_i (word),
    .lane_o (lane),
    .dclk_o (dclk),
    .frame_o(frame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BITS-1:0] pick_word(input int f, input int l);
    case (f % 8)
      1: return {BITS{1'b1}};
      2: return '0;
      3: return (l % 2 == 0) ? BITS'(12'hAAA) : BITS'(12'h555);
      4: return BITS'(12'h800);
      5: return BITS'(12'h7FF);
      6: return BITS'(l * 12'h111 + 1);
      default: return BITS'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [BITS-1:0] exp_w  [LANES];
    logic [BITS-1:0] next_w [LANES];
    logic [BITS-1:0] rx     [LANES];
    void'($urandom(32'd20240611));
    for (int l = 0; l < LANES; l++) begin
      exp_w[l] = '0;
      next_w[l] = '0;
      rx[l] = '0;
    end
    word = {LANES*BITS{1'b1}};
    repeat (3) @(negedge clk);
    // R6: state during reset
    check(lane == '0, "R6 lanes in reset", int'(lane), 0);
    check(frame == 1'b1, "R6 frame in reset", int'(frame), 1);
    check(dclk == 1'b0, "R6 dclk in reset", int'(dclk), 0);
    rst_n = 1'b1;

    for (int f = 0; f < NFRM; f++) begin
      for (int p = 0; p < BITS; p++) begin
        for (int l = 0; l < LANES; l++) rx[l] = {rx[l][BITS-2:0], lane[l]};
        check(frame == (p < HALF), "R2 frame level", int'(frame), int'(p < HALF));
        check(dclk == p[0], "R3 dclk phase", int'(dclk), p % 2);
        if (p == 0) check(!dclk && frame, "R4 frame start on dclk low",
                          int'({frame, dclk}), 2);
        if (p == 0) begin
          for (int l = 0; l < LANES; l++) word[l*BITS +: BITS] = BITS'($urandom);
        end else if (p == HALF - 1) begin
          for (int l = 0; l < LANES; l++) word[l*BITS +: BITS] = ~word[l*BITS +: BITS];
        end else if (p == BITS - 2) begin
          for (int l = 0; l < LANES; l++) begin
            next_w[l] = pick_word(f, l);
            word[l*BITS +: BITS] = next_w[l];
          end
        end
        @(negedge clk);
      end
      for (int l = 0; l < LANES; l++) begin
        if (f == 0) check(rx[l] == '0, "R6 first frame zero", int'(rx[l]), 0);
        else        check(rx[l] == exp_w[l], "R1 R5 R7 recovered word",
                          int'(rx[l]), int'(exp_w[l]));
        exp_w[l] = next_w[l];
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule